// File: doc/BRIEF.md
# Dual-Bank Infrared Link Interrupt Controller

This block collects the event pulses of an infrared link controller and turns them into a single interrupt request. It keeps two independent register banks: one serves the slow, UART-style signalling mode and the other serves the faster framed modes. A shared transfer-mode register selects which bank receives incoming events. The same register also carries per-group mask bits that can silence a whole bank at once.

Each bank has a source register, a mask register and a write-one-to-clear register, all with the same bit layout. Software typically follows a fixed start-up order. It sets every mask, clears every source, selects a mode and then unmasks the group and the events of the active bank. After that it services the interrupt by reading the source register and writing the bits it has handled back to the clear register. Events that are pending in the inactive bank still raise the interrupt, so a mode change never hides work that has not been handled.

Top module: `irlink_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, both source registers read 0x0000, both bank masks read 0x8B80, the transfer-mode register reads 0x0111 (UART-style mode, all three group masks set) and irq is 0.
- R2: Event input bits map to source bits as follows: evt_pulse[4] maps to bit 15 (receive frame done), evt_pulse[3] to bit 11 (buffer overflow), evt_pulse[2] to bit 9 (receive timeout in UART-style mode, abort in framed modes), evt_pulse[1] to bit 8 (framing error in UART-style mode, CRC error in framed modes) and evt_pulse[0] to bit 7 (transmit done). A pulse sets its bit at the next clock edge, and the bit stays set until it is cleared.
- R3: The mode field in bits 15:14 of the transfer-mode register routes events. Value 00 routes them to the UART-style bank and values 10 and 11 route them to the framed bank. With value 01 events reach neither bank. The bank that is not selected never gains a bit.
- R4: Writing to a clear register (UART-style bank 0x14, framed bank 0x24) clears every source bit written as 1. Bits written as 0 keep their value.
- R5: If an event and a clear of the same source bit happen in the same cycle, the bit ends up set.
- R6: A bank mask bit at 1 (UART-style bank mask at 0x12, framed bank mask at 0x22) stops the matching source bit from raising irq.
- R7: Group mask bits in the transfer-mode register gate whole banks. Bit 0 at 1 blocks the UART-style bank and bit 4 at 1 blocks the framed bank. Bit 8 is only stored and has no effect on irq.
- R8: irq is 1 exactly when some source bit, in either bank, has both its bank mask bit and its group mask bit at 0. This includes the bank that the current mode does not select. irq follows register state in the same cycle.
- R9: The transfer-mode register at 0x00 stores bits 15, 14, 8, 4 and 0 on a write. All other bits of that register read as 0.
- R10: Source and mask registers read 0 in every bit position other than 15, 11, 9, 8 and 7. Clear registers read as 0x0000.
- R11: Reads from unmapped offsets (for example 0x16 and 0x30) return 0x0000, and writes to them change no register.
- R12: Writes to a source register (UART-style bank 0x10, framed bank 0x20) are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for one register write in this cycle |
| bus_addr | input | ADDR_W (8) | Byte offset of the register, 16-bit aligned |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| evt_pulse | input | 5 | Event pulses from the link logic, one cycle each |
| irq | output | 1 | Interrupt request, active high |

## Verification
A corrupted source bit shows on the ports in two ways: irq moves in the cycle right after the bad edge, and the next read of the source register returns the wrong value. A routing fault shows up as a bit appearing in the bank that the mode did not select. A clear with the wrong priority shows up as a source bit missing one cycle after an event collided with a clear. The bench keeps a behavioural model of both banks and the mode register. It compares irq after every clock edge and compares each register read against the model, so a fault is reported within one cycle of the stimulus that exposes it.

// File: rtl/irlink_irq_pkg.sv
// Package: shared constants, types and helpers for the infrared link
// interrupt controller. Assumes 16-bit registers and byte offsets.
package irlink_irq_pkg;

    localparam int REG_W     = 16;
    localparam int N_EVT     = 5;
    localparam int N_BANK    = 2;

    // Source bit positions that exist in every bank.
    localparam logic [REG_W-1:0] EVT_BITS = 16'h8B80;

    // Writable bits of the transfer-mode register.
    localparam logic [REG_W-1:0] MODE_RW  = 16'hC111;
    localparam logic [REG_W-1:0] MODE_RST = 16'h0111;

    localparam int GM_UART_BIT  = 0;
    localparam int GM_FRAME_BIT = 4;

    // Address map, byte offsets.
    localparam int ADR_MODE    = 'h00;
    localparam int ADR_BANK0   = 'h10;
    localparam int BANK_STRIDE = 'h10;
    localparam int OFS_SRC     = 'h0;
    localparam int OFS_MASK    = 'h2;
    localparam int OFS_CLR     = 'h4;

    typedef enum logic [1:0] {
        MODE_UART = 2'b00,
        MODE_RSVD = 2'b01,
        MODE_FAST = 2'b10,
        MODE_MED  = 2'b11
    } link_mode_e;

    // Spread the five event pulses onto their register bit positions.
    function automatic logic [REG_W-1:0] evt_to_bits(input logic [N_EVT-1:0] e);
        logic [REG_W-1:0] r;
        r     = '0;
        r[15] = e[4];
        r[11] = e[3];
        r[9]  = e[2];
        r[8]  = e[1];
        r[7]  = e[0];
        return r;
    endfunction

endpackage

// File: rtl/irlink_addr_dec.sv
// Address decoder: turns the byte offset and write strobe into per-register
// hit and write-enable signals. Assumes offsets are 16-bit aligned and that
// a bank occupies BANK_STRIDE bytes starting at ADR_BANK0.
module irlink_addr_dec
    import irlink_irq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output logic              hit_mode,
    output logic              we_mode,
    output logic [N_BANK-1:0] hit_src,
    output logic [N_BANK-1:0] hit_mask,
    output logic [N_BANK-1:0] we_mask,
    output logic [N_BANK-1:0] we_clr
);

    logic [31:0] addr_ext;
    assign addr_ext = 32'(addr);

    // Decode of the shared transfer-mode register.
    assign hit_mode = (addr_ext == 32'(ADR_MODE));
    assign we_mode  = we && hit_mode;

    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
        localparam int BASE = ADR_BANK0 + b * BANK_STRIDE;
        // Per-bank register hits; clear has no read path.
        assign hit_src[b]  = (addr_ext == 32'(BASE + OFS_SRC));
        assign hit_mask[b] = (addr_ext == 32'(BASE + OFS_MASK));
        assign we_mask[b]  = we && hit_mask[b];
        assign we_clr[b]   = we && (addr_ext == 32'(BASE + OFS_CLR));
    end

endmodule

// File: rtl/irlink_mode_reg.sv
// Transfer-mode register: holds the 2-bit link mode and the three group mask
// bits. Assumes only MODE_RW bits are storage; all others read as zero.
module irlink_mode_reg
    import irlink_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rd,
    output link_mode_e       mode,
    output logic             gm_uart,
    output logic             gm_frame
);

    logic [REG_W-1:0] mode_q;

    // Register update: reset to UART-style mode with every group masked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RST;
        end else if (we) begin
            mode_q <= wdata & MODE_RW;
        end
    end

    assign rd       = mode_q;
    assign mode     = link_mode_e'(mode_q[15:14]);
    assign gm_uart  = mode_q[GM_UART_BIT];
    assign gm_frame = mode_q[GM_FRAME_BIT];

endmodule

// File: rtl/irlink_evt_bank.sv
// One event bank: a sticky source register with write-one-to-clear and a
// mask register. Assumes set_bits is already routed to this bank; a set in
// the same cycle as a clear of the same bit keeps the bit set.
module irlink_evt_bank
    import irlink_irq_pkg::*;
#(
    parameter logic [REG_W-1:0] VALID = EVT_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] set_bits,
    input  logic             mask_we,
    input  logic             clr_we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] src,
    output logic [REG_W-1:0] mask,
    output logic             pend
);

    logic [REG_W-1:0] clr_bits;
    assign clr_bits = clr_we ? wdata : '0;

    // Source latch: clear first, then new events override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src <= '0;
        end else begin
            src <= ((src & ~clr_bits) | set_bits) & VALID;
        end
    end

    // Mask register: all implemented bits masked after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= VALID;
        end else if (mask_we) begin
            mask <= wdata & VALID;
        end
    end

    assign pend = |(src & ~mask);

endmodule

// File: rtl/irlink_irq_ctrl.sv
// Top: dual-bank interrupt controller for an infrared link. Routes event
// pulses to the bank chosen by the mode field, gates each bank by its group
// mask and ORs both banks into irq. Assumes single-cycle event pulses and a
// bus that presents at most one write per cycle.
module irlink_irq_ctrl
    import irlink_irq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [N_EVT-1:0]  evt_pulse,
    output logic              irq
);

    logic                         hit_mode, we_mode;
    logic [N_BANK-1:0]            hit_src, hit_mask, we_mask, we_clr;
    logic [REG_W-1:0]             mode_rd;
    link_mode_e                   mode_q;
    logic                         gm_uart, gm_frame;
    logic [N_BANK-1:0]            route_en, bank_pend, group_open;
    logic [N_BANK-1:0][REG_W-1:0] bank_src, bank_mask;
    logic [REG_W-1:0]             evt_bits;

    irlink_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr     (bus_addr),
        .we       (bus_we),
        .hit_mode (hit_mode),
        .we_mode  (we_mode),
        .hit_src  (hit_src),
        .hit_mask (hit_mask),
        .we_mask  (we_mask),
        .we_clr   (we_clr)
    );

    irlink_mode_reg u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (we_mode),
        .wdata    (bus_wdata),
        .rd       (mode_rd),
        .mode     (mode_q),
        .gm_uart  (gm_uart),
        .gm_frame (gm_frame)
    );

    assign evt_bits = evt_to_bits(evt_pulse);

    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
        if (b == 0) begin : g_uart
            // UART-style bank takes events only in mode 00.
            assign route_en[b]   = (mode_q == MODE_UART);
            assign group_open[b] = !gm_uart;
        end else begin : g_frame
            // Framed bank takes events in modes 10 and 11.
            assign route_en[b]   = mode_q[1];
            assign group_open[b] = !gm_frame;
        end

        irlink_evt_bank #(.VALID(EVT_BITS)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_bits (route_en[b] ? evt_bits : '0),
            .mask_we  (we_mask[b]),
            .clr_we   (we_clr[b]),
            .wdata    (bus_wdata),
            .src      (bank_src[b]),
            .mask     (bank_mask[b]),
            .pend     (bank_pend[b])
        );
    end

    // Read mux: unmapped offsets and clear registers return zero.
    always_comb begin
        bus_rdata = '0;
        if (hit_mode) bus_rdata = mode_rd;
        for (int b = 0; b < N_BANK; b++) begin
            if (hit_src[b])  bus_rdata = bank_src[b];
            if (hit_mask[b]) bus_rdata = bank_mask[b];
        end
    end

    assign irq = |(bank_pend & group_open);

endmodule

// File: rtl/irlink_irq_chk.sv
// Checker: temporal properties of the interrupt controller, bound to the top.
module irlink_irq_chk
    import irlink_irq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic [N_EVT-1:0]  evt_pulse,
    input logic              irq,
    input logic [1:0]        mode,
    input logic              gm_uart,
    input logic              gm_frame,
    input logic [REG_W-1:0]  u_src,
    input logic [REG_W-1:0]  u_mask,
    input logic [REG_W-1:0]  f_src,
    input logic [REG_W-1:0]  f_mask
);

    logic uclr_wr;
    assign uclr_wr = bus_we && (32'(bus_addr) == 32'(ADR_BANK0 + OFS_CLR));

    // R2: receive-done pulse in UART-style mode sets bit 15.
    a_r2_uart_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && evt_pulse[4]) |=> u_src[15]);

    // R4: a 1 written to the clear register drops the bit.
    a_r4_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (uclr_wr && bus_wdata[15] && !(mode == 2'b00 && evt_pulse[4])) |=> !u_src[15]);

    // R5: event and clear in the same cycle leave the bit set.
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (uclr_wr && bus_wdata[11] && mode == 2'b00 && evt_pulse[3]) |=> u_src[11]);

    // R3: framed bank gains nothing while UART-style mode is selected.
    a_r3_frame_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> ((f_src & ~$past(f_src)) == '0));

    // R3: reserved mode routes to no bank.
    a_r3_rsvd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |=> (((u_src & ~$past(u_src)) == '0) && ((f_src & ~$past(f_src)) == '0)));

    // R7: both groups masked means no interrupt.
    a_r7_groups_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (gm_uart && gm_frame) |-> !irq);

    // R6: no unmasked source bit means no interrupt.
    a_r6_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (((u_src & ~u_mask) == '0) && ((f_src & ~f_mask) == '0)) |-> !irq);

endmodule

bind irlink_irq_ctrl irlink_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .evt_pulse (evt_pulse),
    .irq       (irq),
    .mode      (mode_q),
    .gm_uart   (gm_uart),
    .gm_frame  (gm_frame),
    .u_src     (bank_src[0]),
    .u_mask    (bank_mask[0]),
    .f_src     (bank_src[1]),
    .f_mask    (bank_mask[1])
);

// File: tb/irlink_irq_ctrl_tb.sv
module irlink_irq_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    localparam int A_MODE = 'h00;
    localparam int A_USRC = 'h10;
    localparam int A_UMSK = 'h12;
    localparam int A_UCLR = 'h14;
    localparam int A_FSRC = 'h20;
    localparam int A_FMSK = 'h22;
    localparam int A_FCLR = 'h24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [4:0]  evt_pulse = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    // Behavioural reference state.
    logic [15:0] m_src [2];
    logic [15:0] m_mask [2];
    logic [15:0] m_mode;

    always #(CLK_PERIOD/2) clk = ~clk;

    irlink_irq_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt_pulse (evt_pulse),
        .irq       (irq)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] m_read(int a);
        case (a)
            A_MODE: return m_mode;
            A_USRC: return m_src[0];
            A_UMSK: return m_mask[0];
            A_FSRC: return m_src[1];
            A_FMSK: return m_mask[1];
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic m_irq();
        logic u, f;
        u = ((m_src[0] & ~m_mask[0]) != 0) && !m_mode[0];
        f = ((m_src[1] & ~m_mask[1]) != 0) && !m_mode[4];
        return u || f;
    endfunction

    task automatic m_reset();
        m_src[0] = 16'h0; m_src[1] = 16'h0;
        m_mask[0] = 16'h8B80; m_mask[1] = 16'h8B80;
        m_mode = 16'h0111;
    endtask

    task automatic m_step(bit we, int a, logic [15:0] wd, logic [4:0] e);
        logic [15:0] s;
        int tgt;
        s = 16'h0;
        if (e[4]) s = s | 16'h8000;
        if (e[3]) s = s | 16'h0800;
        if (e[2]) s = s | 16'h0200;
        if (e[1]) s = s | 16'h0100;
        if (e[0]) s = s | 16'h0080;
        if (m_mode[15:14] == 2'b00) tgt = 0;
        else if (m_mode[15]) tgt = 1;
        else tgt = -1;
        for (int b = 0; b < 2; b++) begin
            logic [15:0] c;
            c = (we && a == ((b == 0) ? A_UCLR : A_FCLR)) ? wd : 16'h0;
            m_src[b] = (m_src[b] & ~c) | ((tgt == b) ? s : 16'h0);
            if (we && a == ((b == 0) ? A_UMSK : A_FMSK)) m_mask[b] = wd & 16'h8B80;
        end
        if (we && a == A_MODE) m_mode = wd & 16'hC111;
    endtask

    // One clock with optional write and events; irq compared after the edge.
    task automatic cyc(string tag, bit we, int a, logic [15:0] wd, logic [4:0] e);
        @(negedge clk);
        bus_we = we; bus_addr = 8'(a); bus_wdata = wd; evt_pulse = e;
        @(posedge clk);
        m_step(we, a, wd, e);
        #2;
        chk({tag, " irq"}, {15'h0, irq}, {15'h0, m_irq()});
    endtask

    task automatic rd(string tag, int a);
        @(negedge clk);
        bus_we = 1'b0; evt_pulse = '0; bus_addr = 8'(a);
        #1;
        chk(tag, bus_rdata, m_read(a));
    endtask

    task automatic rdx(string tag, int a, logic [15:0] exp);
        @(negedge clk);
        bus_we = 1'b0; evt_pulse = '0; bus_addr = 8'(a);
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 irq", {15'h0, irq}, 16'h0);
        rdx("R1 mode", A_MODE, 16'h0111);
        rdx("R1 umask", A_UMSK, 16'h8B80);
        rdx("R1 fmask", A_FMSK, 16'h8B80);
        rdx("R1 usrc", A_USRC, 16'h0000);
        rdx("R1 fsrc", A_FSRC, 16'h0000);

        // R7: events while group masked and bank masked give no irq
        cyc("R7", 1'b0, 0, 16'h0, 5'b10000);
        rdx("R2 usrc bit15", A_USRC, 16'h8000);
        // open UART group and bank mask
        cyc("R9", 1'b1, A_MODE, 16'h0110, 5'b0);
        cyc("R6", 1'b1, A_UMSK, 16'h0000, 5'b0);
        rdx("R8 irq pending", A_USRC, 16'h8000);
        chk("R8 irq", {15'h0, irq}, 16'h1);
        // R2 each remaining event bit
        cyc("R2", 1'b0, 0, 16'h0, 5'b01000);
        cyc("R2", 1'b0, 0, 16'h0, 5'b00100);
        cyc("R2", 1'b0, 0, 16'h0, 5'b00010);
        cyc("R2", 1'b0, 0, 16'h0, 5'b00001);
        rdx("R2 all bits", A_USRC, 16'h8B80);
        // R4 write-one-to-clear
        cyc("R4", 1'b1, A_UCLR, 16'h0800, 5'b0);
        rdx("R4 cleared bit11", A_USRC, 16'h8380);
        cyc("R4", 1'b1, A_UCLR, 16'h0000, 5'b0);
        rdx("R4 zero write keeps", A_USRC, 16'h8380);
        rdx("R10 clr reads zero", A_UCLR, 16'h0000);
        // R5 set wins over clear
        cyc("R5", 1'b1, A_UCLR, 16'h8000, 5'b10000);
        rdx("R5 set wins", A_USRC, 16'h8380);
        // R12 writes to source ignored
        cyc("R12", 1'b1, A_USRC, 16'h0000, 5'b0);
        rdx("R12 src unchanged", A_USRC, 16'h8380);
        // R6 bank mask blocks
        cyc("R6", 1'b1, A_UMSK, 16'hFFFF, 5'b0);
        chk("R6 masked irq", {15'h0, irq}, 16'h0);
        rdx("R10 mask bits", A_UMSK, 16'h8B80);
        cyc("R6", 1'b1, A_UMSK, 16'h7FFF, 5'b0);
        chk("R6 one bit open", {15'h0, irq}, 16'h1);
        cyc("R4", 1'b1, A_UCLR, 16'hFFFF, 5'b0);
        rdx("R4 all cleared", A_USRC, 16'h0000);

        // R3 fast mode routes to framed bank
        cyc("R9", 1'b1, A_MODE, 16'h8101, 5'b0);
        rdx("R9 mode readback", A_MODE, 16'h8101);
        cyc("R6", 1'b1, A_FMSK, 16'h0000, 5'b0);
        cyc("R3", 1'b0, 0, 16'h0, 5'b00110);
        rdx("R3 framed got events", A_FSRC, 16'h0300);
        rdx("R3 uart untouched", A_USRC, 16'h0000);
        chk("R3 irq framed", {15'h0, irq}, 16'h1);
        // R3 medium mode
        cyc("R3", 1'b1, A_MODE, 16'hC101, 5'b0);
        cyc("R3", 1'b0, 0, 16'h0, 5'b00001);
        rdx("R3 medium routes framed", A_FSRC, 16'h0380);
        // R3 reserved mode routes nowhere
        cyc("R3", 1'b1, A_MODE, 16'h4101, 5'b0);
        cyc("R3", 1'b0, 0, 16'h0, 5'b11111);
        rdx("R3 rsvd framed", A_FSRC, 16'h0380);
        rdx("R3 rsvd uart", A_USRC, 16'h0000);
        // R7 framed group mask and FIFO bit
        cyc("R7", 1'b1, A_MODE, 16'h8011, 5'b0);
        chk("R7 frame group closed", {15'h0, irq}, 16'h0);
        cyc("R7", 1'b1, A_MODE, 16'h8100, 5'b0);
        chk("R7 fifo bit no effect", {15'h0, irq}, 16'h1);
        // R8 pending in non-selected bank still raises irq
        cyc("R8", 1'b1, A_MODE, 16'h0000, 5'b0);
        chk("R8 inactive bank irq", {15'h0, irq}, 16'h1);
        cyc("R8", 1'b1, A_FCLR, 16'hFFFF, 5'b0);
        chk("R8 cleared", {15'h0, irq}, 16'h0);
        // R9 unused mode bits
        cyc("R9", 1'b1, A_MODE, 16'hFFFF, 5'b0);
        rdx("R9 unused zero", A_MODE, 16'hC111);
        // R11 unmapped
        cyc("R11", 1'b1, 'h16, 16'hFFFF, 5'b0);
        cyc("R11", 1'b1, 'h30, 16'hFFFF, 5'b0);
        rdx("R11 read 0x16", 'h16, 16'h0000);
        rdx("R11 read 0x30", 'h30, 16'h0000);
        rd("R11 mode kept", A_MODE);
        rd("R11 umask kept", A_UMSK);
        rd("R11 fmask kept", A_FMSK);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule